// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects 8-bit words with a Hamming code of four check bits, giving 12-bit codewords. It holds two independent streaming paths. The encode path takes a data word and returns the codeword. The decode path takes a received codeword and returns the repaired data word, the raw syndrome and a set of classification flags. Each path has one register stage with a valid/ready handshake on both sides.

Codeword positions are numbered 1 to 12, and position p is stored in codeword bit p-1. The check bits sit at the power-of-two positions. The data bits fill the other positions in ascending order. The check value is the XOR of the position numbers of all data bits that are 1.

The decoder recomputes that value from the received data bits and XORs it with the received check bits to form the syndrome. It then sorts the syndrome into one of four classes. A syndrome of zero means the word is clean. A one-hot syndrome means a check bit was hit, and the data passes through unchanged. Any other syndrome up to 12 names the position of a flipped data bit, and that bit is inverted. A syndrome above 12 cannot name a position, so it is flagged as uncorrectable and the data passes through.

On each side the handshake follows the same rules. A transfer happens on a clock edge where valid and ready are both high. An input port is ready when its stage is empty or when the downstream side is taking the stage's result in the same cycle. While an output is valid and not taken, the output and all of its flags hold steady.

Top module: `hamc_codec`

## Requirements
- R1: The encoder places data bit d[i] (i = 0..7) at codeword positions 3, 5, 6, 7, 9, 10, 11, 12 in ascending order of i. Check bit k goes to position 2^k. Position p is codeword bit p-1.
- R2: Check bit k equals bit k of the XOR of the position numbers of all data bits that are 1. Data 8'h39 encodes to 12'h34F, with check value 4'b0111.
- R3: A received codeword with syndrome 0 returns its data bits unchanged, with syndrome 0 and all four flags low.
- R4: When one data bit is flipped, the syndrome equals that bit's position and the data bit is inverted back. The error and corrected flags are high. The check-hit and uncorrectable flags are low. Example: flipping position 6 of 12'h34F gives syndrome 4'b0110 and data 8'h39.
- R5: A one-hot syndrome (a flipped check bit) sets the error and check-hit flags. The data passes through unchanged and the corrected flag stays low.
- R6: A syndrome of 13, 14 or 15 sets the error and uncorrectable flags. The received data bits pass through uncorrected and the corrected flag stays low.
- R7: Each path has one register stage. A word accepted on a clock edge appears at the output valid right after that edge, with its flags and syndrome in the same cycle. With the output ready held high, the path takes one word every cycle.
- R8: An input port's ready is high when its stage is empty or its output is being taken. While an output is valid and its ready is low, the output data, syndrome and flags stay stable and no new word is accepted.
- R9: After reset, both output valids are low and both input readies are high.
- R10: The encode and decode paths are independent. A stall on one does not stop transfers on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Data word to encode is present |
| enc_in_ready | output | 1 | Encode path can accept a word |
| enc_in_data | input | 8 | Data word to encode |
| enc_out_valid | output | 1 | Codeword is present |
| enc_out_ready | input | 1 | Downstream takes the codeword |
| enc_out_code | output | 12 | Codeword, bit p-1 holds position p |
| dec_in_valid | input | 1 | Received codeword is present |
| dec_in_ready | output | 1 | Decode path can accept a codeword |
| dec_in_code | input | 12 | Received codeword |
| dec_out_valid | output | 1 | Decoded result is present |
| dec_out_ready | input | 1 | Downstream takes the result |
| dec_out_data | output | 8 | Repaired data word |
| dec_out_syndrome | output | 4 | Raw syndrome |
| dec_out_err | output | 1 | Nonzero syndrome |
| dec_out_fixed | output | 1 | A data bit was inverted |
| dec_out_chkhit | output | 1 | Syndrome is one-hot (check bit hit) |
| dec_out_uncorr | output | 1 | Syndrome above 12, data not repaired |

## Verification
A wrong position table or a wrong check-bit XOR shows up as a wrong codeword on the very next cycle after an encode is accepted. A bad syndrome or a bad class shows up just as fast on the decode side, as a wrong syndrome, a wrong flag, or the wrong data bit flipped. For this reason every single-bit flip of a known codeword is decoded and compared. A stage whose full flag or ready logic is wrong shows up within a cycle or two of a stall. It appears as a result that changes while held, a word that is dropped or repeated, or a ready that stays low after the stall is released.

// File: rtl/hamc_pkg.sv
package hamc_pkg;

  // Syndrome classes used by the decoder
  typedef enum logic [1:0] {
    SYN_CLEAN  = 2'd0,
    SYN_CHECK  = 2'd1,
    SYN_DATA   = 2'd2,
    SYN_BEYOND = 2'd3
  } syn_cls_e;

  // Smallest number of check bits r with 2^r >= data + r + 1
  function automatic int chk_bits_for(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position (1-based) of data bit idx: the idx-th non power of two
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hamc_enc.sv
module hamc_enc #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = hamc_pkg::chk_bits_for(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CHK_W-1:0] chk;

  always_comb begin
    chk = '0;
    for (int i = 0; i < DATA_W; i++)
      if (data[i]) chk = chk ^ CHK_W'(hamc_pkg::data_pos(i));
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < DATA_W; i++)
      code[hamc_pkg::data_pos(i) - 1] = data[i];
    for (int k = 0; k < CHK_W; k++)
      code[(1 << k) - 1] = chk[k];
  end
endmodule

// File: rtl/hamc_dec.sv
module hamc_dec #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = hamc_pkg::chk_bits_for(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [CODE_W-1:0]  code,
  output logic [DATA_W-1:0]  data,
  output logic [CHK_W-1:0]   syn,
  output hamc_pkg::syn_cls_e cls
);
  logic [DATA_W-1:0] rx_data;
  logic [CHK_W-1:0]  rx_chk;
  logic [CHK_W-1:0]  calc;

  always_comb begin
    calc = '0;
    for (int i = 0; i < DATA_W; i++) begin
      rx_data[i] = code[hamc_pkg::data_pos(i) - 1];
      if (rx_data[i]) calc = calc ^ CHK_W'(hamc_pkg::data_pos(i));
    end
    for (int k = 0; k < CHK_W; k++)
      rx_chk[k] = code[(1 << k) - 1];
    syn = calc ^ rx_chk;
  end

  always_comb begin
    if (syn == '0)
      cls = hamc_pkg::SYN_CLEAN;
    else if ((syn & (syn - 1'b1)) == '0)
      cls = hamc_pkg::SYN_CHECK;
    else if (32'(syn) > CODE_W)
      cls = hamc_pkg::SYN_BEYOND;
    else
      cls = hamc_pkg::SYN_DATA;
  end

  always_comb begin
    data = rx_data;
    if (cls == hamc_pkg::SYN_DATA)
      for (int i = 0; i < DATA_W; i++)
        if (hamc_pkg::data_pos(i) == 32'(syn)) data[i] = ~rx_data[i];
  end
endmodule

// File: rtl/hamc_pipe.sv
module hamc_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] hold;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign out_data  = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_ready) begin
      full <= in_valid;
      if (in_valid) hold <= in_data;
    end
  end

  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  no_accept_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/hamc_codec.sv
module hamc_codec #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = hamc_pkg::chk_bits_for(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic [CHK_W-1:0]  dec_out_syndrome,
  output logic              dec_out_err,
  output logic              dec_out_fixed,
  output logic              dec_out_chkhit,
  output logic              dec_out_uncorr
);
  localparam int DEC_W = DATA_W + CHK_W + 4;

  // Encode path
  logic [CODE_W-1:0] enc_code;

  hamc_enc #(.DATA_W(DATA_W)) enc_i (
    .data (enc_in_data),
    .code (enc_code)
  );

  hamc_pipe #(.W(CODE_W)) enc_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_code),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  // Decode path
  logic [DATA_W-1:0]  dec_data;
  logic [CHK_W-1:0]   dec_syn;
  hamc_pkg::syn_cls_e dec_cls;
  logic [DEC_W-1:0]   dec_pack;
  logic [DEC_W-1:0]   dec_res;

  hamc_dec #(.DATA_W(DATA_W)) dec_i (
    .code (dec_in_code),
    .data (dec_data),
    .syn  (dec_syn),
    .cls  (dec_cls)
  );

  assign dec_pack = {dec_data, dec_syn,
                     dec_cls != hamc_pkg::SYN_CLEAN,
                     dec_cls == hamc_pkg::SYN_DATA,
                     dec_cls == hamc_pkg::SYN_CHECK,
                     dec_cls == hamc_pkg::SYN_BEYOND};

  hamc_pipe #(.W(DEC_W)) dec_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_pack),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_res)
  );

  assign {dec_out_data, dec_out_syndrome, dec_out_err,
          dec_out_fixed, dec_out_chkhit, dec_out_uncorr} = dec_res;

  // R4 R5 R6
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> $onehot0({dec_out_fixed, dec_out_chkhit, dec_out_uncorr}));

  // R5
  chkhit_onehot_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_chkhit) |-> ($countones(dec_out_syndrome) == 1 && dec_out_err));

  // R4
  fixed_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_fixed) |->
      (dec_out_err && 32'(dec_out_syndrome) <= CODE_W && $countones(dec_out_syndrome) > 1));

  // R3
  clean_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && !dec_out_err) |->
      (dec_out_syndrome == '0 && !dec_out_fixed && !dec_out_chkhit && !dec_out_uncorr));
endmodule

// File: tb/hamc_codec_tb_top.sv
`timescale 1ns/1ps
module hamc_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [7:0]  enc_in_data = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b1;
  logic [11:0] enc_out_code;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [11:0] dec_in_code = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b1;
  logic [7:0]  dec_out_data;
  logic [3:0]  dec_out_syndrome;
  logic        dec_out_err, dec_out_fixed, dec_out_chkhit, dec_out_uncorr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hamc_codec dut_i (.*);

  int dpos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  function automatic logic [11:0] model_enc(input logic [7:0] d);
    logic [11:0] c;
    logic [3:0] v;
    c = '0; v = '0;
    for (int i = 0; i < 8; i++)
      if (d[i]) begin c[dpos[i]-1] = 1'b1; v = v ^ 4'(dpos[i]); end
    c[0] = v[0]; c[1] = v[1]; c[3] = v[2]; c[7] = v[3];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic enc_one(input logic [7:0] d, input logic [11:0] exp, input string req);
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_data = d;
    @(negedge clk);
    enc_in_valid = 1'b0;
    check(enc_out_valid && enc_out_code == exp, req, "codeword", int'(enc_out_code), int'(exp));
  endtask

  task automatic dec_one(input logic [11:0] c, input logic [7:0] ed, input logic [3:0] es,
                         input logic [3:0] eflags, input string req);
    logic [3:0] fl;
    @(negedge clk);
    dec_in_valid = 1'b1; dec_in_code = c;
    @(negedge clk);
    dec_in_valid = 1'b0;
    fl = {dec_out_err, dec_out_fixed, dec_out_chkhit, dec_out_uncorr};
    check(dec_out_valid && dec_out_data == ed, req, "data", int'(dec_out_data), int'(ed));
    check(dec_out_syndrome == es, req, "syndrome", int'(dec_out_syndrome), int'(es));
    check(fl == eflags, req, "flags err/fixed/chk/unc", int'(fl), int'(eflags));
  endtask

  task automatic t_reset();
    check(!enc_out_valid, "R9", "enc_out_valid", int'(enc_out_valid), 0);
    check(!dec_out_valid, "R9", "dec_out_valid", int'(dec_out_valid), 0);
    check(enc_in_ready, "R9", "enc_in_ready", int'(enc_in_ready), 1);
    check(dec_in_ready, "R9", "dec_in_ready", int'(dec_in_ready), 1);
  endtask

  task automatic t_enc_example();
    enc_one(8'h39, 12'h34F, "R2");
  endtask

  task automatic t_enc_patterns();
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
    foreach (pats[j]) enc_one(pats[j], model_enc(pats[j]), "R1");
    for (int i = 0; i < 8; i++) enc_one(8'(1 << i), model_enc(8'(1 << i)), "R1");
  endtask

  task automatic t_dec_clean();
    dec_one(12'h34F, 8'h39, 4'h0, 4'b0000, "R3");
    dec_one(model_enc(8'hC3), 8'hC3, 4'h0, 4'b0000, "R3");
  endtask

  task automatic t_dec_data_flips();
    dec_one(12'h36F, 8'h39, 4'b0110, 4'b1100, "R4");
    for (int i = 0; i < 8; i++)
      dec_one(model_enc(8'h96) ^ (12'h1 << (dpos[i]-1)), 8'h96, 4'(dpos[i]), 4'b1100, "R4");
  endtask

  task automatic t_dec_check_flips();
    for (int k = 0; k < 4; k++)
      dec_one(12'h34F ^ (12'h1 << ((1 << k) - 1)), 8'h39, 4'(1 << k), 4'b1010, "R5");
  endtask

  task automatic t_dec_beyond();
    // positions 12 and 1 flipped: syndrome 13, data bit 7 stays flipped
    dec_one(12'hB4E, 8'hB9, 4'd13, 4'b1001, "R6");
    // positions 12 and 3 flipped: syndrome 15
    dec_one(12'h34F ^ 12'h804, 8'h38 ^ 8'h80, 4'd15, 4'b1001, "R6");
  endtask

  task automatic t_stream();
    logic [7:0] seq [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
    @(negedge clk);
    enc_out_ready = 1'b1;
    enc_in_valid = 1'b1; enc_in_data = seq[0];
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(enc_out_valid && enc_out_code == model_enc(seq[j]), "R7", "streamed codeword",
            int'(enc_out_code), int'(model_enc(seq[j])));
      if (j < 3) enc_in_data = seq[j+1]; else enc_in_valid = 1'b0;
    end
    @(negedge clk);
    check(!enc_out_valid, "R7", "valid after stream", int'(enc_out_valid), 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    dec_out_ready = 1'b0;
    dec_in_valid = 1'b1; dec_in_code = 12'h36F;
    @(negedge clk);
    dec_in_code = model_enc(8'h77);
    check(!dec_in_ready, "R8", "ready while stalled", int'(dec_in_ready), 0);
    // R10: encoder keeps flowing while decoder is stalled
    enc_in_valid = 1'b1; enc_in_data = 8'h39;
    @(negedge clk);
    enc_in_valid = 1'b0;
    check(enc_out_valid && enc_out_code == 12'h34F, "R10", "enc during dec stall",
          int'(enc_out_code), 12'h34F);
    repeat (2) @(negedge clk);
    check(dec_out_valid && dec_out_data == 8'h39 && dec_out_syndrome == 4'd6 && dec_out_fixed,
          "R8", "held result", int'({dec_out_data, dec_out_syndrome}), 12'h396);
    dec_out_ready = 1'b1;
    #0.5;
    check(dec_in_ready, "R8", "ready when taken", int'(dec_in_ready), 1);
    @(negedge clk);
    dec_in_valid = 1'b0;
    check(dec_out_valid && dec_out_data == 8'h77 && !dec_out_err, "R8", "next after release",
          int'(dec_out_data), 8'h77);
    @(negedge clk);
    check(!dec_out_valid, "R8", "drained", int'(dec_out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enc_example();
    t_enc_patterns();
    t_dec_clean();
    t_dec_data_flips();
    t_dec_check_flips();
    t_dec_beyond();
    t_stream();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule